// File: doc/BRIEF.md
# UART Interrupt Source Identification

This block is the interrupt front end of a FIFO-capable UART. Each clock it gathers the raw event conditions from the neighbouring receiver, transmitter, FIFO and modem logic. It masks them with a four-bit enable register and registers two results: an identification byte that names the single most urgent enabled source, and a level interrupt output that is high whenever any enabled source is pending.

The receive-data source depends on the FIFO mode. With FIFOs on, it fires when the receive FIFO fill level reaches a programmable trigger level. With FIFOs off, it fires whenever the buffer holds a character. A character-timeout source counts character-time ticks while unread data sits in the FIFO and no new character arrives. The transmit-empty source is an edge-armed latch. Reading the identification byte while it names that source clears the latch, and so does writing the holding register.

Top module: `uart_irq_ident`

## Requirements
- R1: A write strobe on `ier_wr` stores `ier_wdata[3:0]` into the enable register. From the next cycle `ier_out[3:0]` shows the stored value and `ier_out[7:4]` reads zero. The enable bits are: bit 0 receive data and timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status.
- R2: `iir[3:1]` holds the code of the highest enabled pending source. The order, from most to least urgent, is: line status 3'b011, receive data 3'b010, timeout 3'b110, transmit empty 3'b001, modem status 3'b000. A less urgent source that stays pending is reported once the more urgent ones are gone.
- R3: `iir[0]` is 0 when a source is pending and 1 when none is. `irq` is high exactly when a source is pending. Both are registered, so they reflect the inputs and state of the previous cycle.
- R4: `iir[7:6]` reads 2'b11 when the previous cycle had `fifo_en` high, and 2'b00 otherwise. `iir[5:4]` reads zero.
- R5: With `fifo_en` high, the receive-data source is pending when `rx_count` is at least the trigger level. `trig_sel` 00, 01, 10 and 11 select levels 1, 4, 8 and 14. With `fifo_en` low, the source is pending when `rx_count` is nonzero.
- R6: The line-status source is pending while any bit of `rx_err` (overrun, parity, framing, break) is set.
- R7: With `fifo_en` high and `rx_count` nonzero, four `char_tick` pulses without `rx_push` or `rbr_rd` set the timeout condition one cycle after the fourth tick. `rx_push`, `rbr_rd`, an empty FIFO or FIFOs off clear the condition and restart the count.
- R8: A rising edge of `thr_empty` arms the transmit-empty latch, and `irq` reflects it one cycle later. `thr_wr` clears the latch. `iir_rd` clears it when it falls in a cycle where `iir[3:1]` is 3'b001 and `iir[0]` is 0. A clear wins over a simultaneous arm.
- R9: A source whose enable bit is 0 is never reported and never raises `irq`. With all enable bits at 0, `irq` stays low.
- R10: After reset the enable register is 0, `iir` is 8'h01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| fifo_en | input | 1 | FIFO mode active |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_err | input | 4 | Line error flags: overrun, parity, framing, break |
| rx_push | input | 1 | A new character entered the receive FIFO |
| rbr_rd | input | 1 | CPU read of the receive buffer |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holding register empty level |
| thr_wr | input | 1 | CPU write of the transmit holding register |
| msr_change | input | 1 | Modem status change pending |
| iir_rd | input | 1 | CPU read of the identification byte |
| ier_out | output | 8 | Enable register readback |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The critical collisions are several sources becoming pending in the same cycle, and a clear event landing in the same cycle as the event that would re-arm a source. The bench raises line errors, a trigger-level fill, modem change and transmit-empty together, then removes them one at a time. It expects the reported code to step down the priority order. Random stimulus also makes `iir_rd` coincide with a rising `thr_empty` and with `thr_wr`. Each cycle's identification byte and interrupt level are compared with a cycle-accurate reference computed from the requirements.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        SRC_MODEM   = 3'b000,
        SRC_THRE    = 3'b001,
        SRC_RXDATA  = 3'b010,
        SRC_LINE    = 3'b011,
        SRC_TIMEOUT = 3'b110
    } irq_code_e;

    localparam int EN_RX    = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_W     = 4;

    typedef struct packed {
        logic [EN_W-1:0] ier;
        logic            empty_seen;
        logic            thre;
        logic [7:0]      iir;
        logic            irq;
    } irq_state_t;

endpackage

// File: rtl/uart_irq_level.sv
module uart_irq_level #(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             fifo_en,
    output logic             rx_hit
);
    localparam int NLEV = 4;
    localparam logic [CNT_W-1:0] LEVELS [NLEV] = '{
        CNT_W'(1), CNT_W'(4), CNT_W'(8), CNT_W'(14)
    };

    logic [NLEV-1:0] reached;

    for (genvar g = 0; g < NLEV; g++) begin : g_lev
        assign reached[g] = (rx_count >= LEVELS[g]);
    end

    always_comb begin
        if (fifo_en) rx_hit = reached[trig_sel];
        else         rx_hit = (rx_count != '0);
    end
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
    parameter int CNT_W    = 5,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rbr_rd,
    input  logic             char_tick,
    output logic             timeout
);
    localparam int TCNT_W = $clog2(TO_CHARS + 1);

    logic [TCNT_W-1:0] cnt_d, cnt_q;
    logic              tmo_d, tmo_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!fifo_en || rx_count == '0 || rx_push || rbr_rd) begin
            cnt_d = '0;
        end else if (char_tick && cnt_q < TCNT_W'(TO_CHARS)) begin
            cnt_d = cnt_q + 1'b1;
        end
        tmo_d = (cnt_d == TCNT_W'(TO_CHARS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tmo_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            tmo_q <= tmo_d;
        end
    end

    assign timeout = tmo_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic      line_p,
    input  logic      rxd_p,
    input  logic      tmo_p,
    input  logic      thre_p,
    input  logic      modem_p,
    output irq_code_e code,
    output logic      pending
);
    always_comb begin
        if (line_p)      code = SRC_LINE;
        else if (rxd_p)  code = SRC_RXDATA;
        else if (tmo_p)  code = SRC_TIMEOUT;
        else if (thre_p) code = SRC_THRE;
        else             code = SRC_MODEM;
        pending = line_p | rxd_p | tmo_p | thre_p | modem_p;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [7:0]       ier_wdata,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [3:0]       rx_err,
    input  logic             rx_push,
    input  logic             rbr_rd,
    input  logic             char_tick,
    input  logic             thr_empty,
    input  logic             thr_wr,
    input  logic             msr_change,
    input  logic             iir_rd,
    output logic [7:0]       ier_out,
    output logic [7:0]       iir,
    output logic             irq
);
    irq_state_t st_d, st_q;

    logic      rx_hit, tmo;
    logic      pending;
    irq_code_e code;

    uart_irq_level #(.CNT_W(CNT_W)) i_level (
        .rx_count (rx_count),
        .trig_sel (trig_sel),
        .fifo_en  (fifo_en),
        .rx_hit   (rx_hit)
    );

    uart_irq_timeout #(.CNT_W(CNT_W), .TO_CHARS(TO_CHARS)) i_timeout (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .rx_count  (rx_count),
        .rx_push   (rx_push),
        .rbr_rd    (rbr_rd),
        .char_tick (char_tick),
        .timeout   (tmo)
    );

    uart_irq_prio i_prio (
        .line_p  ((|rx_err) & st_q.ier[EN_LINE]),
        .rxd_p   (rx_hit & st_q.ier[EN_RX]),
        .tmo_p   (tmo & st_q.ier[EN_RX]),
        .thre_p  (st_q.thre & st_q.ier[EN_THRE]),
        .modem_p (msr_change & st_q.ier[EN_MODEM]),
        .code    (code),
        .pending (pending)
    );

    always_comb begin
        st_d = st_q;
        if (ier_wr) st_d.ier = ier_wdata[EN_W-1:0];

        st_d.empty_seen = thr_empty;
        if (thr_empty && !st_q.empty_seen) st_d.thre = 1'b1;
        if (thr_wr) st_d.thre = 1'b0;
        if (iir_rd && st_q.iir[3:1] == SRC_THRE && !st_q.iir[0]) st_d.thre = 1'b0;

        st_d.iir = {{2{fifo_en}}, 2'b00, code, ~pending};
        st_d.irq = pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ier: '0, empty_seen: 1'b0, thre: 1'b0, iir: 8'h01, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ier_out = {{(8-EN_W){1'b0}}, st_q.ier};
    assign iir     = st_q.iir;
    assign irq     = st_q.irq;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ier_wr,
    input logic [7:0]       ier_wdata,
    input logic             fifo_en,
    input logic [CNT_W-1:0] rx_count,
    input logic [3:0]       rx_err,
    input logic [7:0]       ier_out,
    input logic [7:0]       iir,
    input logic             irq
);
    assert_ier_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> (ier_out[3:0] == $past(ier_wdata[3:0])) && (ier_out[7:4] == 4'h0));

    assert_line_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_err != 4'h0) && ier_out[2] && !ier_wr) |=> (iir[3:1] == 3'b011) && !iir[0] && irq);

    assert_fifo_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (iir[7:6] == {2{$past(fifo_en)}}) && (iir[5:4] == 2'b00));

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_out[3:0] == 4'h0) |=> !irq && iir[0]);

    assert_no_data_no_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rx_count == '0) |=> (iir[3:1] != 3'b010));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier_wr    (ier_wr),
    .ier_wdata (ier_wdata),
    .fifo_en   (fifo_en),
    .rx_count  (rx_count),
    .rx_err    (rx_err),
    .ier_out   (ier_out),
    .iir       (iir),
    .irq       (irq)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ier_wr = 1'b0;
    logic [7:0]       ier_wdata = '0;
    logic             fifo_en = 1'b0;
    logic [1:0]       trig_sel = '0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [3:0]       rx_err = '0;
    logic             rx_push = 1'b0;
    logic             rbr_rd = 1'b0;
    logic             char_tick = 1'b0;
    logic             thr_empty = 1'b0;
    logic             thr_wr = 1'b0;
    logic             msr_change = 1'b0;
    logic             iir_rd = 1'b0;
    logic [7:0]       ier_out, iir;
    logic             irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference state
    logic [3:0] m_ier = '0;
    logic       m_prev = 1'b0, m_thre = 1'b0, m_to = 1'b0, m_irq = 1'b0;
    int         m_cnt = 0;
    logic [7:0] m_iir = 8'h01;

    always #5 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W), .TO_CHARS(4)) i_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .fifo_en(fifo_en), .trig_sel(trig_sel), .rx_count(rx_count),
        .rx_err(rx_err), .rx_push(rx_push), .rbr_rd(rbr_rd),
        .char_tick(char_tick), .thr_empty(thr_empty), .thr_wr(thr_wr),
        .msr_change(msr_change), .iir_rd(iir_rd),
        .ier_out(ier_out), .iir(iir), .irq(irq)
    );

    function automatic int trig_level(input logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] make_iir(input logic f, input logic [2:0] c, input logic p);
        return {{2{f}}, 2'b00, c, ~p};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: compute reference next state, advance, compare
    task automatic step(input string req);
        logic [3:0] n_ier;
        logic       n_thre, n_to, ls, rd, tm, th, ms, pend;
        int         n_cnt;
        logic [2:0] c;
        n_ier = ier_wr ? ier_wdata[3:0] : m_ier;
        n_thre = m_thre | (thr_empty & ~m_prev);
        if (thr_wr) n_thre = 1'b0;
        if (iir_rd && m_iir[3:1] == 3'b001 && !m_iir[0]) n_thre = 1'b0;
        n_cnt = m_cnt;
        if (!fifo_en || rx_count == 0 || rx_push || rbr_rd) n_cnt = 0;
        else if (char_tick && m_cnt < 4) n_cnt = m_cnt + 1;
        n_to = (n_cnt == 4);
        ls = (rx_err != 0) & m_ier[2];
        rd = (fifo_en ? (int'(rx_count) >= trig_level(trig_sel)) : (rx_count != 0)) & m_ier[0];
        tm = m_to & m_ier[0];
        th = m_thre & m_ier[1];
        ms = msr_change & m_ier[3];
        pend = ls | rd | tm | th | ms;
        c = ls ? 3'b011 : rd ? 3'b010 : tm ? 3'b110 : th ? 3'b001 : 3'b000;
        @(posedge clk);
        #1;
        m_ier = n_ier; m_prev = thr_empty; m_thre = n_thre;
        m_cnt = n_cnt; m_to = n_to;
        m_iir = make_iir(fifo_en, c, pend); m_irq = pend;
        check({req, " iir"}, int'(iir), int'(m_iir));
        check({req, " irq"}, int'(irq), int'(m_irq));
        check({req, " ier"}, int'(ier_out), int'({4'h0, m_ier}));
    endtask

    task automatic idle_pulses();
        ier_wr = 1'b0; rx_push = 1'b0; rbr_rd = 1'b0;
        char_tick = 1'b0; thr_wr = 1'b0; iir_rd = 1'b0;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2718);
        #23;
        // R10: reset state
        check("R10 iir", int'(iir), 8'h01);
        check("R10 irq", int'(irq), 0);
        check("R10 ier", int'(ier_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1: upper enable bits read zero
        ier_wr = 1'b1; ier_wdata = 8'hF0;
        step("R1");
        idle_pulses();
        step("R1");
        check("R1 upper", int'(ier_out), 0);
        step("R9");

        // R5: trigger levels with FIFOs on
        fifo_en = 1'b1;
        ier_wr = 1'b1; ier_wdata = 8'h01;
        step("R1");
        idle_pulses();
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            rx_count = CNT_W'(trig_level(2'(s)) - 1);
            step("R5");
            step("R5");
            rx_count = CNT_W'(trig_level(2'(s)));
            step("R5");
            check("R5 level", int'(iir), int'(make_iir(1'b1, 3'b010, 1'b1)));
        end
        fifo_en = 1'b0; rx_count = CNT_W'(1);
        step("R4");
        step("R5");
        check("R5 nofifo", int'(iir), int'(make_iir(1'b0, 3'b010, 1'b1)));

        // R7: timeout after four ticks, cleared by read
        fifo_en = 1'b1; trig_sel = 2'b11; rx_count = CNT_W'(3);
        step("R7");
        for (int t = 0; t < 4; t++) begin
            char_tick = 1'b1; step("R7");
            char_tick = 1'b0; step("R7");
        end
        step("R7");
        check("R7 timeout", int'(iir), int'(make_iir(1'b1, 3'b110, 1'b1)));
        rbr_rd = 1'b1; step("R7");
        rbr_rd = 1'b0; step("R7");
        check("R7 cleared", int'(irq), 0);

        // R8: transmit empty arm and clear by identification read
        rx_count = '0;
        ier_wr = 1'b1; ier_wdata = 8'h02; step("R8");
        idle_pulses();
        thr_empty = 1'b1; step("R8"); step("R8");
        check("R8 armed", int'(iir), int'(make_iir(1'b1, 3'b001, 1'b1)));
        iir_rd = 1'b1; step("R8");
        iir_rd = 1'b0; step("R8"); step("R8");
        check("R8 cleared", int'(irq), 0);

        // R2/R6: collision of all sources, then step down the order
        ier_wr = 1'b1; ier_wdata = 8'h0F; thr_wr = 1'b1; thr_empty = 1'b0; step("R2");
        idle_pulses();
        thr_empty = 1'b1; rx_err = 4'b0100; rx_count = CNT_W'(14);
        msr_change = 1'b1; step("R6"); step("R6");
        check("R6 line first", int'(iir[3:1]), 3);
        rx_err = '0; step("R2");
        check("R2 rx second", int'(iir[3:1]), 2);
        rx_count = '0; step("R2");
        check("R2 thre third", int'(iir[3:1]), 1);
        thr_wr = 1'b1; step("R8");
        thr_wr = 1'b0; step("R2");
        check("R2 modem last", int'(iir[3:1]), 0);
        msr_change = 1'b0; step("R3");
        check("R3 none", int'(iir[0]), 1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            ier_wr     = ($urandom_range(0, 15) == 0);
            ier_wdata  = 8'($urandom);
            fifo_en    = ($urandom_range(0, 7) != 0);
            trig_sel   = 2'($urandom);
            rx_count   = CNT_W'($urandom_range(0, 16));
            rx_err     = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
            rx_push    = ($urandom_range(0, 9) == 0);
            rbr_rd     = ($urandom_range(0, 9) == 0);
            char_tick  = ($urandom_range(0, 1) == 0);
            thr_empty  = ($urandom_range(0, 3) != 0) ? thr_empty : ~thr_empty;
            thr_wr     = ($urandom_range(0, 11) == 0);
            msr_change = ($urandom_range(0, 3) == 0);
            iir_rd     = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 3) == 0) rx_count = i_hold(rx_count);
            step("R2 R3 R5 R7 R8 random");
        end
        idle_pulses();
        finish_run();
    end

    function automatic logic [CNT_W-1:0] i_hold(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(2) : v;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule